// File: doc/BRIEF.md
# MDIO Management Controller

This block lets a register bus drive Clause 22 management transactions towards an external Ethernet PHY. Software places a 16-bit value in the data register (for writes), then writes a single 16-bit command word that carries the direction, the 5-bit PHY address and the 5-bit register offset. The write of that command word launches a serial frame on the MDC/MDIO pins. The frame is a preamble of ones, a start pattern, an opcode, both addresses, a turnaround and 16 data bits.

Progress is polled through a finish flag held in the top bit of the command readback. The flag drops as soon as a command is accepted and returns high once the last frame bit has been clocked out. For a read, the 16 bits returned by the PHY land in the data register at that same moment. Because the line idles high through a pull-up, an address with no PHY behind it reads back as all ones.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, done is 1, mdc is 0, mdio_oe is 0, mdio_o is 1, ctl_rd reads 0x8000 and data_rd reads 0x0000.
- R2: In a command word, bit 13 set selects a write and bit 13 clear selects a read. Bits 12:8 hold the PHY address and bits 4:0 the register offset. ctl_rd returns these three fields in the same positions, returns the finish flag in bit 15, and returns zero in bits 14 and 7:5.
- R3: A command write accepted while idle clears the finish flag (ctl_rd bit 15 and done) from the next clock. The flag sets again exactly (PRE_LEN+32)*CLK_DIV clocks after the accepting edge, which is 2560 clocks with default parameters.
- R4: mdc stays low while idle. While busy it first rises CLK_DIV/2 clocks after the accepting edge. It then repeats with a period of CLK_DIV clocks, high for CLK_DIV/2 of them.
- R5: A write frame, sampled on rising mdc, is PRE_LEN ones, 01, opcode 01, the PHY address and then the register offset (each MSB first), turnaround 10, and then the data register value as it stood at the accepting edge, MSB first. mdio_oe is 1 for every bit.
- R6: A read frame carries opcode 10. mdio_oe is 1 up to the last offset bit and 0 from the first turnaround bit through the end of the frame.
- R7: During a read, the 16 data bits are taken from mdio_i at each rising mdc edge, MSB first, and written to data_rd on the clock where done rises.
- R8: A command write that arrives while busy is ignored: ctl_rd, the frame in progress and its finish time are unchanged, and no further transaction follows.
- R9: mdio_o changes only where mdc falls or where a transaction completes. The line is released (mdio_oe 0) whenever done is 1.
- R10: A data register write sets data_rd from the next clock. data_rd changes only through such a write or the completion of a read, so a write transaction leaves it unchanged.
- R11: A read from an address where no PHY drives the line (mdio_i held high) returns 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Command register write strobe |
| data_we | input | 1 | Data register write strobe |
| bus_wdata | input | 16 | Write data for either register |
| ctl_rd | output | 16 | Command register readback, finish flag in bit 15 |
| data_rd | output | 16 | Data register readback |
| done | output | 1 | Finish flag, 1 when idle |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
Each result of this block is due at a fixed cycle relative to the clock edge that accepts a command. The finish flag drops on the first sample after that edge. mdc first rises CLK_DIV/2 clocks later, and the flag and any read data return (PRE_LEN+32)*CLK_DIV clocks after it. The bench drives every stimulus on the falling system clock and samples on falling edges, counting them from the accepting edge, so each count matches one of those figures exactly. A PHY model registers each frame bit on rising mdc and presents its read bits after falling mdc. This lets the checks compare whole frames and output-enable patterns instead of single snapshots.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int CMD_DONE_BIT = 15;
  localparam int CMD_WR_BIT   = 13;
  localparam int CMD_PHY_LSB  = 8;
  localparam int CMD_REG_LSB  = 0;
  localparam int ADDR_W       = 5;
  localparam int WORD_W       = 16;
  localparam int BODY_BITS    = 32;   // start+op+addrs+ta+data
  localparam int HDR_BITS     = 14;   // start+op+phy+reg

  localparam logic [1:0] SOF_PAT   = 2'b01;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;
  localparam logic [1:0] TA_DRIVE  = 2'b10;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } mdio_cmd_t;

  // Body of a frame after the preamble; read frames carry ones where the
  // line is released so the output simply idles high there.
  function automatic logic [BODY_BITS-1:0] build_body(mdio_cmd_t c,
                                                      logic [WORD_W-1:0] d);
    if (c.wr)
      return {SOF_PAT, OPC_WRITE, c.phy, c.regad, TA_DRIVE, d};
    else
      return {SOF_PAT, OPC_READ, c.phy, c.regad, 2'b11, {WORD_W{1'b1}} & ~(d & '0)};
  endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int CLK_DIV = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic mdc,
  output logic rise_tk,
  output logic fall_tk
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

  logic [CW-1:0] cnt;

  assign rise_tk = en && (cnt == CW'(HALF - 1));
  assign fall_tk = en && (cnt == CW'(CLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (fall_tk) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (rise_tk) mdc <= 1'b1;
    end
  end
endmodule

// File: rtl/mdio_cmd_regs.sv
module mdio_cmd_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic              data_we,
  input  logic [WORD_W-1:0] wdata,
  input  mdio_cmd_t         new_cmd,
  input  logic              busy,
  input  logic              rd_load,
  input  logic [WORD_W-1:0] rd_value,
  output logic              start,
  output mdio_cmd_t         cmd_q,
  output logic [WORD_W-1:0] data_q
);
  assign start = ctl_we && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= '0;
      data_q <= '0;
    end else begin
      if (start) cmd_q <= new_cmd;
      if (rd_load)      data_q <= rd_value;
      else if (data_we) data_q <= wdata;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_cmd_t         new_cmd,
  input  logic [WORD_W-1:0] wdata_q,
  input  logic              rise_tk,
  input  logic              fall_tk,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              rd_load,
  output logic [WORD_W-1:0] rd_value
);
  localparam int TOTAL    = PRE_LEN + BODY_BITS;
  localparam int BCW      = $clog2(TOTAL + 1);
  localparam int TA_IDX   = PRE_LEN + HDR_BITS;
  localparam int DATA_IDX = PRE_LEN + HDR_BITS + 2;

  logic [BCW-1:0]       bitcnt;
  logic [BCW-1:0]       nxt_idx;
  logic [BODY_BITS-1:0] body;
  logic                 is_rd;
  logic [WORD_W-1:0]    rx;
  logic                 last_bit;
  logic [4:0]           fsel;
  logic                 nxt_bit;
  logic                 nxt_rel;

  assign last_bit = (bitcnt == BCW'(TOTAL - 1));
  assign nxt_idx  = bitcnt + 1'b1;
  assign fsel     = 5'(TOTAL - 1 - int'(nxt_idx));
  assign nxt_bit  = (int'(nxt_idx) < PRE_LEN) ? 1'b1 : body[fsel];
  assign nxt_rel  = is_rd && (int'(nxt_idx) >= TA_IDX);
  assign rd_load  = busy && fall_tk && last_bit && is_rd;
  assign rd_value = rx;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      bitcnt  <= '0;
      body    <= '0;
      is_rd   <= 1'b0;
      rx      <= '0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      bitcnt  <= '0;
      body    <= build_body(new_cmd, wdata_q);
      is_rd   <= !new_cmd.wr;
      mdio_o  <= (PRE_LEN > 0) ? 1'b1 : SOF_PAT[1];
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise_tk && is_rd && (int'(bitcnt) >= DATA_IDX))
        rx <= {rx[WORD_W-2:0], mdio_i};
      if (fall_tk) begin
        if (last_bit) begin
          busy    <= 1'b0;
          bitcnt  <= '0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          bitcnt  <= nxt_idx;
          mdio_o  <= nxt_bit;
          mdio_oe <= !nxt_rel;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 40,
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ctl_we,
  input  logic        data_we,
  input  logic [15:0] bus_wdata,
  output logic [15:0] ctl_rd,
  output logic [15:0] data_rd,
  output logic        done,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  mdio_cmd_t         new_cmd;
  mdio_cmd_t         cmd_q;
  logic              start;
  logic              busy;
  logic              rise_tk;
  logic              fall_tk;
  logic              rd_load;
  logic [WORD_W-1:0] rd_value;
  logic [WORD_W-1:0] data_q;

  assign new_cmd.wr    = bus_wdata[CMD_WR_BIT];
  assign new_cmd.phy   = bus_wdata[CMD_PHY_LSB +: ADDR_W];
  assign new_cmd.regad = bus_wdata[CMD_REG_LSB +: ADDR_W];

  mdio_cmd_regs u_regs (
    .clk      (clk),
    .rst      (rst),
    .ctl_we   (ctl_we),
    .data_we  (data_we),
    .wdata    (bus_wdata),
    .new_cmd  (new_cmd),
    .busy     (busy),
    .rd_load  (rd_load),
    .rd_value (rd_value),
    .start    (start),
    .cmd_q    (cmd_q),
    .data_q   (data_q)
  );

  mdio_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk     (clk),
    .rst     (rst),
    .en      (busy),
    .mdc     (mdc),
    .rise_tk (rise_tk),
    .fall_tk (fall_tk)
  );

  mdio_shifter #(.PRE_LEN(PRE_LEN)) u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .new_cmd  (new_cmd),
    .wdata_q  (data_q),
    .rise_tk  (rise_tk),
    .fall_tk  (fall_tk),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rd_load  (rd_load),
    .rd_value (rd_value)
  );

  assign done    = !busy;
  assign data_rd = data_q;
  assign ctl_rd  = {!busy, 1'b0, cmd_q.wr, cmd_q.phy, 3'b000, cmd_q.regad};
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk #(
  parameter int CLK_DIV = 40
) (
  input logic        clk,
  input logic        rst,
  input logic        ctl_we,
  input logic        data_we,
  input logic [15:0] ctl_rd,
  input logic [15:0] data_rd,
  input logic        done,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  localparam int HALF = CLK_DIV / 2;
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !mdc) hi_cnt <= 0;
    else             hi_cnt <= hi_cnt + 1;
  end

  // R3: the finish flag only drops after a command write
  a_r3_done_drops_on_cmd: assert property (@(posedge clk) disable iff (rst)
    $fell(done) |-> $past(ctl_we));

  // R8: a command write while busy leaves the command fields alone
  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (!done && ctl_we) |=> $stable(ctl_rd[14:0]));

  // R4: no clock to the PHY while idle
  a_r4_mdc_low_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !mdc);

  // R4: each high phase of mdc lasts half the divider
  a_r4_mdc_high_half: assert property (@(posedge clk) disable iff (rst)
    $fell(mdc) |-> (hi_cnt == HALF));

  // R9: line released whenever idle
  a_r9_line_released_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !mdio_oe);

  // R9: output value moves only on a falling mdc or at completion
  a_r9_out_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(mdio_o) |-> ($fell(mdc) || $rose(done)));

  // R10: data register changes only by software write or read completion
  a_r10_data_changes_only: assert property (@(posedge clk) disable iff (rst)
    !$stable(data_rd) |-> ($past(data_we) || $rose(done)));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk #(.CLK_DIV(CLK_DIV)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ctl_we  (ctl_we),
  .data_we (data_we),
  .ctl_rd  (ctl_rd),
  .data_rd (data_rd),
  .done    (done),
  .mdc     (mdc),
  .mdio_o  (mdio_o),
  .mdio_oe (mdio_oe)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  localparam int DIV   = 40;
  localparam int PRE   = 32;
  localparam int FLEN  = PRE + 32;
  localparam int TXN   = FLEN * DIV;
  localparam logic [4:0] PHY_ADR = 5'd3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic        data_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] ctl_rd, data_rd;
  logic        done, mdc, mdio_o, mdio_oe, mdio_i;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mdio_mgmt_ctrl #(.CLK_DIV(DIV), .PRE_LEN(PRE)) dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .data_we(data_we),
    .bus_wdata(bus_wdata), .ctl_rd(ctl_rd), .data_rd(data_rd),
    .done(done), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // PHY model
  logic [15:0] phy_mem [32];
  logic [63:0] cap = '0, oecap = '0, frame_last = '0, oe_last = '0;
  int          pcount = 0;
  logic        phy_rd = 1'b0, drv = 1'b0, dval = 1'b1;
  logic [15:0] rd_word = '0;
  logic        line_v;

  assign line_v = mdio_oe ? mdio_o : (drv ? dval : 1'b1);
  assign mdio_i = line_v;

  initial for (int i = 0; i < 32; i++) phy_mem[i] = 16'h1000 + 16'(i);

  always @(posedge mdc) begin
    cap   = {cap[62:0], line_v};
    oecap = {oecap[62:0], mdio_oe};
    pcount++;
    if (pcount == FLEN) begin
      frame_last = cap;
      oe_last    = oecap;
      pcount     = 0;
      if (cap[29:28] == 2'b01 && cap[27:23] == PHY_ADR)
        phy_mem[cap[22:18]] = cap[15:0];
    end
  end

  always @(negedge mdc) begin
    if (pcount == PRE + 14) begin
      phy_rd  = (cap[11:10] == 2'b10) && (cap[9:5] == PHY_ADR);
      rd_word = phy_mem[cap[4:0]];
    end
    if (phy_rd && pcount == PRE + 15) begin
      drv = 1'b1; dval = 1'b0;
    end else if (phy_rd && pcount >= PRE + 16) begin
      drv = 1'b1; dval = rd_word[FLEN - 1 - pcount];
    end else begin
      drv = 1'b0; dval = 1'b1;
    end
    if (pcount == 0) phy_rd = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w);
    @(negedge clk); ctl_we = 1'b1; bus_wdata = w;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic set_data(input logic [15:0] w);
    @(negedge clk); data_we = 1'b1; bus_wdata = w;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!done) begin @(negedge clk); n++; end
  endtask

  function automatic logic [15:0] cmdw(input bit wr, input logic [4:0] p,
                                       input logic [4:0] r);
    return {2'b00, wr, p, 3'b000, r};
  endfunction

  task automatic t_reset;
    chk(done == 1'b1 && mdc == 1'b0, "R1 done/mdc", {done, mdc}, 2'b10);
    chk(mdio_oe == 1'b0 && mdio_o == 1'b1, "R1 mdio pins", {mdio_oe, mdio_o}, 2'b01);
    chk(ctl_rd == 16'h8000, "R1 ctl_rd", ctl_rd, 16'h8000);
    chk(data_rd == 16'h0000, "R1 data_rd", data_rd, 0);
  endtask

  task automatic t_write(input logic [4:0] p, input logic [4:0] r,
                         input logic [15:0] v);
    int n;
    logic [63:0] exp;
    set_data(v);
    chk(data_rd == v, "R10 data write", data_rd, v);
    issue(cmdw(1'b1, p, r));
    chk(done == 1'b0 && ctl_rd[15] == 1'b0, "R3 flag drops", ctl_rd, 0);
    chk(ctl_rd == cmdw(1'b1, p, r), "R2 readback", ctl_rd, cmdw(1'b1, p, r));
    wait_done(n);
    chk(n == TXN, "R3 finish time", n, TXN);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, v};
    chk(frame_last == exp, "R5 write frame", frame_last, exp);
    chk(oe_last == '1, "R5 write oe", oe_last, '1);
    chk(data_rd == v, "R10 data kept after write", data_rd, v);
  endtask

  task automatic t_read(input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] ev, input string req);
    int n;
    logic [45:0] eh;
    issue(cmdw(1'b0, p, r));
    chk(ctl_rd == cmdw(1'b0, p, r), "R2 read readback", ctl_rd, cmdw(1'b0, p, r));
    wait_done(n);
    chk(n == TXN, "R3 read finish time", n, TXN);
    eh = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    chk(frame_last[63:18] == eh, "R6 read header", frame_last[63:18], eh);
    chk(oe_last == {{46{1'b1}}, 18'h0}, "R6 read oe release", oe_last,
        {{46{1'b1}}, 18'h0});
    chk(data_rd == ev, req, data_rd, ev);
    chk(ctl_rd[15] == 1'b1, "R3 flag set", ctl_rd, 16'h8000);
  endtask

  task automatic t_mdc_shape;
    int n, hi, lo;
    issue(cmdw(1'b0, PHY_ADR, 5'd1));
    n = 0;
    while (!mdc) begin @(negedge clk); n++; end
    chk(n == DIV / 2, "R4 first rise", n, DIV / 2);
    hi = 0; while (mdc)  begin @(negedge clk); hi++; end
    lo = 0; while (!mdc) begin @(negedge clk); lo++; end
    chk(hi == DIV / 2 && lo == DIV / 2, "R4 duty", {hi[15:0], lo[15:0]},
        {16'(DIV / 2), 16'(DIV / 2)});
    wait_done(n);
    chk(data_rd == 16'h1001, "R7 read reg1", data_rd, 16'h1001);
  endtask

  task automatic t_busy_ignore;
    int n;
    logic [63:0] exp;
    set_data(16'h5A0F);
    issue(cmdw(1'b1, PHY_ADR, 5'd9));
    repeat (300) @(negedge clk);
    issue(cmdw(1'b0, 5'd17, 5'd2));
    chk(ctl_rd == cmdw(1'b1, PHY_ADR, 5'd9), "R8 ctl unchanged", ctl_rd,
        cmdw(1'b1, PHY_ADR, 5'd9));
    wait_done(n);
    n = n + 302;
    chk(n == TXN, "R8 finish time unchanged", n, TXN);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, PHY_ADR, 5'd9, 2'b10, 16'h5A0F};
    chk(frame_last == exp, "R8 frame unchanged", frame_last, exp);
    repeat (3 * DIV) @(negedge clk);
    chk(done == 1'b1 && mdc == 1'b0, "R8 no follow-up transaction",
        {done, mdc}, 2'b10);
  endtask

  task automatic t_all_ones_cmd;
    int n;
    logic [63:0] exp;
    set_data(16'hC3A5);
    issue(16'hFFFF);
    chk(ctl_rd == 16'h3F1F, "R2 unused bits read zero", ctl_rd, 16'h3F1F);
    wait_done(n);
    exp = {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h1F, 5'h1F, 2'b10, 16'hC3A5};
    chk(frame_last == exp, "R5 max address frame", frame_last, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_read(PHY_ADR, 5'd2, 16'h1002, "R7 read data");
    t_write(PHY_ADR, 5'd4, 16'hA5C3);
    t_read(PHY_ADR, 5'd4, 16'hA5C3, "R7 read back written");
    t_write(PHY_ADR, 5'd31, 16'h8001);
    t_read(PHY_ADR, 5'd31, 16'h8001, "R7 read top offset");
    t_read(5'd7, 5'd2, 16'hFFFF, "R11 absent PHY");
    t_mdc_shape();
    t_busy_ignore();
    t_all_ones_cmd();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule